// File: doc/BRIEF.md
# Event-Type Register Access Trap Arbiter

This block sits beside a bank of per-counter event configuration registers and rules on every system-register access aimed at them. An access is presented for one cycle, either through its direct encoding (five fields that together name one register) or through an indirect alias whose index comes from a separately held select value. The block decides whether the access completes, is turned into a trap with a target privilege level and a syndrome class, or is silently absorbed as read-as-zero/write-ignored.

The decision follows a priority chain that depends on the current privilege level and several trap-control inputs: a user-access enable, a level-2-enabled flag with its general-trap routing bit, a level-2 counter-trap bit, a level-3-present flag with its own counter-trap bit, and a hypervisor-set limit on how many counters lower levels may see. Trap checks win over the range check. Only an access that is neither trapped nor out of range touches the register bank. The verdict and any read data appear on registered outputs one cycle after the request.

Top module: `evtcfg_access_gate`

## Requirements
- R1: A direct access is recognised only when op0=3, op1=3, CRn=14 and CRm[3:2]=3, and its index is {CRm[1:0], op2}. An unrecognised access gives rsp_hit=0, no trap, zero read data and changes no register.
- R2: With req_via_sel=1 the access is recognised whatever the encoding fields hold, and its index is sel_index.
- R3: At level 0 with ctl_user_en=0 the access traps, to level 2 when ctl_l2_en and ctl_tge are both 1, and otherwise to level 1.
- R4: At level 0 with ctl_user_en=1, and at level 1, the access traps to level 2 when ctl_l2_en and ctl_l2_tpm are both 1. Failing that, it traps to level 3 when ctl_l3_present and ctl_l3_tpm are both 1.
- R5: At level 2 the access traps to level 3 only when ctl_l3_present and ctl_l3_tpm are both 1. At level 3 it never traps.
- R6: Every trap reports rsp_ec=0x18. Without a trap, rsp_ec is 0.
- R7: The accessible count is ctl_hpmn at levels 0 and 1 when ctl_l2_en=1, and NUM_CTRS otherwise. An index is in range only when it is below both the accessible count and NUM_CTRS.
- R8: The chain of R3 to R5 takes priority. An untrapped access with an index out of range traps to level 2 when it comes from level 0 or 1 with ctl_l2_en=1 and the index is below NUM_CTRS. Every other out-of-range access reads 0 and its write is ignored.
- R9: A trapped access returns zero read data and leaves every register unchanged.
- R10: A completed write stores req_wdata[31:0] masked with 0xFF80FFFF. A completed read returns that value zero-extended to 64 bits, so bits 63:32 and 22:16 always read 0.
- R11: The rsp_* outputs reflect the request of the previous cycle, with rsp_valid following req_valid. Reset clears rsp_valid, rsp_trap, rsp_ec and rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_via_sel | input | 1 | Use the indirect alias (index from sel_index) |
| sel_index | input | 5 | Select-register index used by the alias |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Current privilege level 0 to 3 |
| ctl_user_en | input | 1 | Level-0 access enable |
| ctl_l2_en | input | 1 | Level 2 implemented and enabled |
| ctl_tge | input | 1 | Route level-0 traps to level 2 |
| ctl_l2_tpm | input | 1 | Level-2 counter-access trap |
| ctl_l3_present | input | 1 | Level 3 implemented |
| ctl_l3_tpm | input | 1 | Level-3 counter-access trap |
| ctl_hpmn | input | 5 | Counters visible below level 2 |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Access was recognised |
| rsp_rdata | output | 64 | Read data |
| rsp_trap | output | 1 | Access trapped |
| rsp_trap_level | output | 2 | Trap target level |
| rsp_ec | output | 6 | Syndrome exception class |

## Verification
The bench runs on a six-counter instance and sweeps all four levels against all 64 settings of the six control flags. Each pass uses four limit values (zero, below, equal to and above the implemented count) and indices inside the bank, beyond it and at 31. This separates chain traps, range traps and absorbed accesses at every boundary of the limit. Writes and reads alternate through the sweep, and a shadow model follows them, so a trapped or absorbed write that leaks into the bank shows up on a later read. Directed cases cover mismatched encoding fields, the indirect alias and the masking of reserved bits on readback.

// File: rtl/evtcfg_pkg.sv
package evtcfg_pkg;
  localparam int IDX_W = 5;
  localparam int EC_W  = 6;
  localparam logic [EC_W-1:0] TRAP_EC = 6'h18;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;

  typedef struct packed {
    logic trap;
    lvl_e target;
    logic razwi;
  } verdict_t;
endpackage

// File: rtl/evtcfg_decode.sv
module evtcfg_decode
  import evtcfg_pkg::*;
(
  input  logic             via_sel,
  input  logic [IDX_W-1:0] sel_index,
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output logic             hit,
  output logic [IDX_W-1:0] index
);
  logic direct_hit;

  always_comb begin
    direct_hit = (op0 == 2'b11) && (op1 == 3'b011) && (crn == 4'b1110) && (crm[3:2] == 2'b11);
    hit        = via_sel || direct_hit;
    index      = via_sel ? sel_index : {crm[1:0], op2};
  end
endmodule

// File: rtl/evtcfg_trap_route.sv
module evtcfg_trap_route
  import evtcfg_pkg::*;
#(
  parameter int NUM_CTRS = 31
) (
  input  lvl_e             level,
  input  logic             user_en,
  input  logic             l2_en,
  input  logic             tge,
  input  logic             l2_tpm,
  input  logic             l3_present,
  input  logic             l3_tpm,
  input  logic [IDX_W-1:0] hpmn,
  input  logic [IDX_W-1:0] index,
  output verdict_t         verdict
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_CTRS);

  logic           chain_trap;
  lvl_e           chain_lvl;
  logic           lower;
  logic           hv_limit;
  logic [IDX_W:0] limit;
  logic           implemented;
  logic           in_range;

  always_comb begin
    lower      = (level == LVL0) || (level == LVL1);
    chain_trap = 1'b0;
    chain_lvl  = LVL0;
    if (level == LVL0 && !user_en) begin
      chain_trap = 1'b1;
      chain_lvl  = (l2_en && tge) ? LVL2 : LVL1;
    end else if (lower && l2_en && l2_tpm) begin
      chain_trap = 1'b1;
      chain_lvl  = LVL2;
    end else if (level != LVL3 && l3_present && l3_tpm) begin
      chain_trap = 1'b1;
      chain_lvl  = LVL3;
    end
  end

  always_comb begin
    hv_limit    = lower && l2_en;
    limit       = hv_limit ? {1'b0, hpmn} : NUM_L;
    implemented = {1'b0, index} < NUM_L;
    in_range    = implemented && ({1'b0, index} < limit);
    verdict     = '{trap: 1'b0, target: LVL0, razwi: 1'b0};
    if (chain_trap) begin
      verdict.trap   = 1'b1;
      verdict.target = chain_lvl;
    end else if (!in_range) begin
      if (hv_limit && implemented) begin
        verdict.trap   = 1'b1;
        verdict.target = LVL2;
      end else begin
        verdict.razwi  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evtcfg_store.sv
module evtcfg_store
  import evtcfg_pkg::*;
#(
  parameter int NUM_CTRS = 31,
  parameter int CFG_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] index,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata
);
  localparam int AW = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;

  logic [CFG_W-1:0] mem [NUM_CTRS];
  logic [AW-1:0]    addr;
  logic             unused_idx;

  assign addr       = index[AW-1:0];
  assign unused_idx = ^index;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  // R8 / R9: the bank is touched only for an index inside it
  a_r8_bank_bounds: assert property (@(posedge clk) disable iff (rst)
    (we || re) |-> (int'(index) < NUM_CTRS));
  a_r9_single_port: assert property (@(posedge clk) disable iff (rst)
    !(we && re));
endmodule

// File: rtl/evtcfg_access_gate.sv
module evtcfg_access_gate
  import evtcfg_pkg::*;
#(
  parameter int          NUM_CTRS  = 31,
  parameter int          DATA_W    = 64,
  parameter int          CFG_W     = 32,
  parameter logic [31:0] KEEP_MASK = 32'hFF80_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_via_sel,
  input  logic [4:0]        sel_index,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_level,
  input  logic              ctl_user_en,
  input  logic              ctl_l2_en,
  input  logic              ctl_tge,
  input  logic              ctl_l2_tpm,
  input  logic              ctl_l3_present,
  input  logic              ctl_l3_tpm,
  input  logic [4:0]        ctl_hpmn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic [1:0]        rsp_trap_level,
  output logic [EC_W-1:0]   rsp_ec
);
  localparam int PAD_W = DATA_W - CFG_W;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  verdict_t         verdict;
  logic             live, fire, wr_en, rd_en;
  logic [CFG_W-1:0] wr_val, bank_q;
  logic             rd_ok_q;
  logic             unused_hi;

  evtcfg_decode u_decode (
    .via_sel  (req_via_sel),
    .sel_index(sel_index),
    .op0      (req_op0),
    .op1      (req_op1),
    .crn      (req_crn),
    .crm      (req_crm),
    .op2      (req_op2),
    .hit      (dec_hit),
    .index    (dec_idx)
  );

  evtcfg_trap_route #(.NUM_CTRS(NUM_CTRS)) u_route (
    .level     (lvl_e'(cur_level)),
    .user_en   (ctl_user_en),
    .l2_en     (ctl_l2_en),
    .tge       (ctl_tge),
    .l2_tpm    (ctl_l2_tpm),
    .l3_present(ctl_l3_present),
    .l3_tpm    (ctl_l3_tpm),
    .hpmn      (ctl_hpmn),
    .index     (dec_idx),
    .verdict   (verdict)
  );

  always_comb begin
    live   = req_valid && dec_hit;
    fire   = live && !verdict.trap && !verdict.razwi;
    wr_en  = fire && req_write;
    rd_en  = fire && !req_write;
    wr_val = req_wdata[CFG_W-1:0] & KEEP_MASK[CFG_W-1:0];
  end

  assign unused_hi = ^req_wdata[DATA_W-1:CFG_W];

  evtcfg_store #(.NUM_CTRS(NUM_CTRS), .CFG_W(CFG_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .re   (rd_en),
    .index(dec_idx),
    .wdata(wr_val),
    .rdata(bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_trap       <= 1'b0;
      rsp_trap_level <= 2'd0;
      rsp_ec         <= '0;
      rd_ok_q        <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= live;
      rsp_trap       <= live && verdict.trap;
      rsp_trap_level <= (live && verdict.trap) ? verdict.target : LVL0;
      rsp_ec         <= (live && verdict.trap) ? TRAP_EC : '0;
      rd_ok_q        <= rd_en;
    end
  end

  assign rsp_rdata = rd_ok_q ? {{PAD_W{1'b0}}, bank_q} : '0;

  // R11: one-cycle response
  a_r11_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_trap);
  // R3: level 0 without user enable always traps upward
  a_r3_user_off_traps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dec_hit && cur_level == 2'd0 && !ctl_user_en) |=> rsp_trap && rsp_trap_level != 2'd0);
  // R5: level 3 is never trapped
  a_r5_top_level_free: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_level == 2'd3) |=> !rsp_trap);
  // R9: trapped accesses return nothing
  a_r9_trap_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> rsp_rdata == '0 && rsp_hit);
  // R1: unrecognised accesses are inert
  a_r1_miss_silent: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> !rsp_trap && rsp_rdata == '0 && rsp_ec == '0);
  // R10: reserved bits never read back
  a_r10_res0_bits: assert property (@(posedge clk) disable iff (rst)
    rsp_rdata[DATA_W-1:CFG_W] == '0 && rsp_rdata[22:16] == 7'd0);
endmodule

// File: tb/test_evtcfg_access_gate.sv
module test_evtcfg_access_gate;
  localparam int NUM = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_via_sel = 0;
  logic [4:0]  sel_index = 0;
  logic [1:0]  req_op0 = 0;
  logic [2:0]  req_op1 = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [2:0]  req_op2 = 0;
  logic [63:0] req_wdata = 0;
  logic [1:0]  cur_level = 0;
  logic        ctl_user_en = 0, ctl_l2_en = 0, ctl_tge = 0, ctl_l2_tpm = 0;
  logic        ctl_l3_present = 0, ctl_l3_tpm = 0;
  logic [4:0]  ctl_hpmn = 0;
  logic        rsp_valid, rsp_hit, rsp_trap;
  logic [63:0] rsp_rdata;
  logic [1:0]  rsp_trap_level;
  logic [5:0]  rsp_ec;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] shadow [NUM];
  int k = 0;

  always #5 clk = ~clk;

  evtcfg_access_gate #(.NUM_CTRS(NUM)) i_evtcfg_access_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_via_sel(req_via_sel), .sel_index(sel_index), .req_op0(req_op0),
    .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .cur_level(cur_level), .ctl_user_en(ctl_user_en),
    .ctl_l2_en(ctl_l2_en), .ctl_tge(ctl_tge), .ctl_l2_tpm(ctl_l2_tpm),
    .ctl_l3_present(ctl_l3_present), .ctl_l3_tpm(ctl_l3_tpm), .ctl_hpmn(ctl_hpmn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .rsp_trap(rsp_trap), .rsp_trap_level(rsp_trap_level), .rsp_ec(rsp_ec)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(input int lv, input int c, input int hp);
    cur_level = 2'(lv);
    {ctl_user_en, ctl_l2_en, ctl_tge, ctl_l2_tpm, ctl_l3_present, ctl_l3_tpm} = 6'(c);
    ctl_hpmn = 5'(hp);
  endtask

  // one access; expectations computed from the requirements
  task automatic access(input bit via, input int sel, input logic [1:0] o0, input logic [2:0] o1,
                        input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
                        input bit wr, input logic [63:0] wd);
    bit hit, trap, in_rng, lowlv, hv;
    int idx, lim, lvl, tl;
    string tag;
    logic [63:0] exp_rd;
    @(negedge clk);
    req_valid = 1; req_via_sel = via; sel_index = 5'(sel);
    req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
    req_write = wr; req_wdata = wd;
    lvl = int'(cur_level);
    hit = via || (o0 == 2'd3 && o1 == 3'd3 && cn == 4'd14 && cm[3:2] == 2'd3);
    idx = via ? sel : int'({cm[1:0], o2});
    trap = 0; tl = 0; tag = "R1";
    lowlv = (lvl <= 1);
    hv = lowlv && ctl_l2_en;
    if (hit) begin
      tag = via ? "R2" : "R10";
      if (lvl == 0 && !ctl_user_en) begin
        trap = 1; tl = (ctl_l2_en && ctl_tge) ? 2 : 1; tag = "R3";
      end else if (lowlv && ctl_l2_en && ctl_l2_tpm) begin
        trap = 1; tl = 2; tag = "R4";
      end else if (lowlv && ctl_l3_present && ctl_l3_tpm) begin
        trap = 1; tl = 3; tag = "R4";
      end else if (lvl == 2 && ctl_l3_present && ctl_l3_tpm) begin
        trap = 1; tl = 3; tag = "R5";
      end
    end
    lim = hv ? int'(ctl_hpmn) : NUM;
    in_rng = (idx < lim) && (idx < NUM);
    if (hit && !trap && !in_rng) begin
      if (hv && idx < NUM) begin trap = 1; tl = 2; tag = "R8"; end
      else tag = "R7";
    end
    exp_rd = 64'd0;
    if (hit && !trap && in_rng) begin
      if (wr) shadow[idx] = wd[31:0] & 32'hFF80_FFFF;
      else exp_rd = {32'd0, shadow[idx]};
    end
    @(negedge clk);
    req_valid = 0;
    check({tag, " verdict"}, {61'd0, rsp_hit, rsp_trap, rsp_valid}, {61'd0, hit, trap, 1'b1});
    check({tag, " target"}, 64'(rsp_trap_level), 64'(tl));
    check("R6 syndrome", 64'(rsp_ec), trap ? 64'h18 : 64'h0);
    check(trap ? "R9 rdata" : {tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic direct(input int idx, input bit wr, input logic [63:0] wd);
    access(0, 0, 2'd3, 3'd3, 4'd14, {2'b11, 2'(idx >> 3)}, 3'(idx), wr, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 reset", {rsp_valid, rsp_trap, rsp_ec, 56'd0}, 64'd0);
    check("R11 reset rdata", rsp_rdata, 64'd0);

    // R10: initialise bank at level 3, reserved bits set in the data
    set_ctl(3, 0, 0);
    for (int i = 0; i < NUM; i++) direct(i, 1, {32'hFFFF_FFFF, 32'h0A5F_0000 + 32'(i * 32'h1111)});
    for (int i = 0; i < NUM; i++) direct(i, 0, 64'd0);

    // R1: near-miss encodings are inert, writes have no effect
    access(0, 0, 2'd2, 3'd3, 4'd14, 4'b1100, 3'd1, 1, 64'hFFFF_FFFF);
    access(0, 0, 2'd3, 3'd2, 4'd14, 4'b1100, 3'd1, 1, 64'hFFFF_FFFF);
    access(0, 0, 2'd3, 3'd3, 4'd13, 4'b1100, 3'd1, 1, 64'hFFFF_FFFF);
    access(0, 0, 2'd3, 3'd3, 4'd14, 4'b1000, 3'd1, 1, 64'hFFFF_FFFF);
    direct(1, 0, 64'd0);

    // R2: indirect alias with garbage encoding fields
    access(1, 2, 2'd0, 3'd0, 4'd0, 4'd0, 3'd0, 1, 64'h0000_0000_1234_5678);
    direct(2, 0, 64'd0);
    access(1, 4, 2'd1, 3'd7, 4'd3, 4'd5, 3'd2, 0, 64'd0);
    access(1, 7, 2'd0, 3'd0, 4'd0, 4'd0, 3'd0, 1, 64'hFFFF_FFFF); // R7 beyond bank

    // sweep: all levels, all control settings, limit values, indices
    for (int lv = 0; lv < 4; lv++)
      for (int c = 0; c < 64; c++)
        for (int h = 0; h < 4; h++)
          for (int j = 0; j < 9; j++) begin
            int hp, ix;
            hp = (h == 0) ? 0 : (h == 1) ? 2 : (h == 2) ? NUM : 9;
            ix = (j == 8) ? 31 : j;
            set_ctl(lv, c, hp);
            k++;
            direct(ix, k[0], {32'hC0DE_0000 ^ 32'(k), 32'(k) * 32'h9E37_79B1});
          end

    // R9 / R10: final readback proves no stray writes
    set_ctl(3, 0, 0);
    for (int i = 0; i < NUM; i++) direct(i, 0, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule